// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 SDRAM interface and brings the memory from power-up to an idle, usable state. After reset it holds clock enable low and drives idle commands. On a start pulse it raises clock enable and then issues a fixed series of eleven commands on the command bus. The series consists of precharge-all, loads of the four mode registers, two auto-refreshes, and the output-driver calibration entry and exit writes. Each command is followed by a run of idle cycles whose length comes from the timing inputs.

The main and extended mode register words are built inside the block from the CAS latency and write recovery inputs. After the last command's wait, the block holds the bus idle for a further settle period so the DLL can lock. It then raises a sticky ready flag that tells the rest of the controller that normal traffic, reads included, may begin.

Top module: `dramInitSeq`

## Requirements
- R1: While reset is low, and on the first cycle after any reset, cke is 0, the bus carries the idle command, ba and addr are all zero, and initDone is 0. Reset may arrive at any point in the sequence and takes effect at once.
- R2: Before a start pulse, the outputs stay as in R1. A start sampled high at a clock edge drives cke to 1 after that edge with the idle command on the bus. The first command appears one cycle later. After that, cke stays 1 until reset, and no command other than idle is driven while cke is 0.
- R3: After start, exactly eleven commands are issued, in this order: precharge-all; mode load bank 2; mode load bank 3; mode load bank 1 (normal); mode load bank 0 (DLL reset); precharge-all; refresh; refresh; mode load bank 0 (no DLL reset); mode load bank 1 (calibration default); mode load bank 1 (calibration exit). The bank 2 and bank 3 loads carry an all-zero addr.
- R4: The pin encodings are {csN,rasN,casN,weN} = 0111 for idle, 0010 for precharge, 0001 for refresh and 0000 for mode load. On every idle cycle, ba and addr are zero.
- R5: A precharge is followed by exactly tRp idle cycles. A mode load is followed by tMrd-1 idle cycles, or 0 when tMrd is 0. A refresh is followed by tRfc-1 idle cycles, or 0 when tRfc is 0. With a wait of 0, the next command follows on the next cycle.
- R6: A bank 0 mode load has addr[2:0]=011 (burst of eight), addr[6:4]=casLat, addr[8]=1 for the DLL-reset load and 0 for the later load, addr[11:9]=wrRec-1, and all other bits 0.
- R7: A bank 1 mode load has addr[2]=1. It has addr[9:7]=111 for the calibration-default load and 000 for the other two. All other bits are 0.
- R8: Every precharge has addr[10]=1 and all other addr bits and ba equal to 0.
- R9: initDone rises after the last command's wait plus DLL_WAIT more idle cycles. After that it stays 1 until reset, and only idle commands are driven.
- R10: A start pulse while the sequence runs, or after initDone is set, has no effect on the bus or on initDone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin initialization (pulse) |
| casLat | input | 3 | CAS latency field for the main mode word |
| wrRec | input | 3 | Write recovery in cycles (field holds wrRec-1) |
| tRp | input | CNT_W | Idle cycles after precharge |
| tMrd | input | CNT_W | Mode-load spacing in cycles |
| tRfc | input | CNT_W | Refresh spacing in cycles |
| cke | output | 1 | Clock enable to the memory |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address / mode word |
| initDone | output | 1 | Sticky ready flag |

## Verification
The sequence is run with three timing sets. A mid-range set gives every command a distinct gap, which reveals any swapped step or miscounted wait. An all-minimum set (tMrd of 0, tRfc of 1) drives commands back to back and exercises the saturating subtraction. A set with a long refresh gap is cut off by reset mid-run to show that reset takes effect at once. Each set uses different CAS latency and write recovery values, so a misplaced mode-word field cannot match by chance. Extra start pulses are sent both during the run and after completion, and the command totals show that no restart occurred.

// File: rtl/dramInitPkg.sv
package dramInitPkg;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PRE,
    CMD_REF,
    CMD_MRS
  } cmdKindE;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_STEP,
    ST_SETTLE,
    ST_DONE
  } seqStateE;

  // strobes from control to datapath
  typedef struct packed {
    logic ckeOn;    // raise clock enable
    logic issue;    // drive current step's command, load its wait
    logic tick;     // count the wait down
    logic loadDll;  // load the DLL settle wait
    logic finish;   // set the ready flag
  } seqStrobeT;

  localparam int unsigned NUM_STEPS   = 11;
  localparam int unsigned STEP_W      = $clog2(NUM_STEPS + 1);
  localparam int unsigned PRE_ALL_BIT = 10;

endpackage

// File: rtl/dramInitCtrl.sv
module dramInitCtrl
  import dramInitPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      waitZero,
  input  logic      lastStep,
  output seqStrobeT strobe
);

  seqStateE state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.ckeOn = 1'b1;
          stateNext    = ST_ARM;
        end
      end
      ST_ARM: begin
        strobe.issue = 1'b1;
        stateNext    = ST_STEP;
      end
      ST_STEP: begin
        if (!waitZero) begin
          strobe.tick = 1'b1;
        end else if (lastStep) begin
          strobe.loadDll = 1'b1;
          stateNext      = ST_SETTLE;
        end else begin
          strobe.issue = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (!waitZero) begin
          strobe.tick = 1'b1;
        end else begin
          strobe.finish = 1'b1;
          stateNext     = ST_DONE;
        end
      end
      ST_DONE: stateNext = ST_DONE;
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/dramInitPath.sv
module dramInitPath
  import dramInitPkg::*;
#(
  parameter int unsigned BA_W     = 3,
  parameter int unsigned ADDR_W   = 14,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned DLL_WAIT = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         strobe,
  input  logic [2:0]        casLat,
  input  logic [2:0]        wrRec,
  input  logic [CNT_W-1:0]  tRp,
  input  logic [CNT_W-1:0]  tMrd,
  input  logic [CNT_W-1:0]  tRfc,
  output logic              waitZero,
  output logic              lastStep,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone
);

  localparam int unsigned DLL_W  = $clog2(DLL_WAIT + 1);
  localparam int unsigned WAIT_W = (CNT_W > DLL_W) ? CNT_W : DLL_W;
  localparam logic [WAIT_W-1:0] SETTLE_LOAD = WAIT_W'(DLL_WAIT - 1);

  logic [STEP_W-1:0] stepIdx;
  logic [WAIT_W-1:0] waitCnt;
  logic [2:0]        pinsN;

  cmdKindE           stepKind;
  logic [BA_W-1:0]   stepBa;
  logic [ADDR_W-1:0] stepAddr;
  logic [CNT_W-1:0]  stepWait;

  function automatic logic [CNT_W-1:0] lessOne(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - CNT_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] mainWord(input logic dllRst,
                                                 input logic [2:0] cl,
                                                 input logic [2:0] wr);
    logic [ADDR_W-1:0] w;
    w       = '0;
    w[2:0]  = 3'b011;
    w[6:4]  = cl;
    w[8]    = dllRst;
    w[11:9] = wr - 3'd1;
    return w;
  endfunction

  function automatic logic [ADDR_W-1:0] extWord(input logic ocdDefault);
    logic [ADDR_W-1:0] w;
    w      = '0;
    w[2]   = 1'b1;
    w[9:7] = ocdDefault ? 3'b111 : 3'b000;
    return w;
  endfunction

  // {rasN, casN, weN}
  function automatic logic [2:0] encodePins(input cmdKindE k);
    case (k)
      CMD_PRE: return 3'b010;
      CMD_REF: return 3'b001;
      CMD_MRS: return 3'b000;
      default: return 3'b111;
    endcase
  endfunction

  // step table: command, bank, address word and following wait
  always_comb begin
    stepKind = CMD_NOP;
    stepBa   = '0;
    stepAddr = '0;
    stepWait = '0;
    case (stepIdx)
      STEP_W'(0), STEP_W'(5): begin
        stepKind              = CMD_PRE;
        stepAddr[PRE_ALL_BIT] = 1'b1;
        stepWait              = tRp;
      end
      STEP_W'(1): begin
        stepKind = CMD_MRS; stepBa = BA_W'(2); stepWait = lessOne(tMrd);
      end
      STEP_W'(2): begin
        stepKind = CMD_MRS; stepBa = BA_W'(3); stepWait = lessOne(tMrd);
      end
      STEP_W'(3), STEP_W'(10): begin
        stepKind = CMD_MRS; stepBa = BA_W'(1); stepAddr = extWord(1'b0);
        stepWait = lessOne(tMrd);
      end
      STEP_W'(4): begin
        stepKind = CMD_MRS; stepAddr = mainWord(1'b1, casLat, wrRec);
        stepWait = lessOne(tMrd);
      end
      STEP_W'(6), STEP_W'(7): begin
        stepKind = CMD_REF; stepWait = lessOne(tRfc);
      end
      STEP_W'(8): begin
        stepKind = CMD_MRS; stepAddr = mainWord(1'b0, casLat, wrRec);
        stepWait = lessOne(tMrd);
      end
      STEP_W'(9): begin
        stepKind = CMD_MRS; stepBa = BA_W'(1); stepAddr = extWord(1'b1);
        stepWait = lessOne(tMrd);
      end
      default: stepKind = CMD_NOP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cke      <= 1'b0;
      pinsN    <= 3'b111;
      ba       <= '0;
      addr     <= '0;
      stepIdx  <= '0;
      waitCnt  <= '0;
      initDone <= 1'b0;
    end else begin
      if (strobe.ckeOn)  cke      <= 1'b1;
      if (strobe.finish) initDone <= 1'b1;
      if (strobe.issue) begin
        pinsN   <= encodePins(stepKind);
        ba      <= stepBa;
        addr    <= stepAddr;
        waitCnt <= WAIT_W'(stepWait);
        stepIdx <= stepIdx + STEP_W'(1);
      end else begin
        pinsN <= 3'b111;
        ba    <= '0;
        addr  <= '0;
        if (strobe.loadDll)   waitCnt <= SETTLE_LOAD;
        else if (strobe.tick) waitCnt <= waitCnt - WAIT_W'(1);
      end
    end
  end

  assign csN               = 1'b0;
  assign {rasN, casN, weN} = pinsN;
  assign waitZero          = (waitCnt == '0);
  assign lastStep          = (stepIdx == STEP_W'(NUM_STEPS));

endmodule

// File: rtl/dramInitSeq.sv
module dramInitSeq
  import dramInitPkg::*;
#(
  parameter int unsigned BA_W     = 3,
  parameter int unsigned ADDR_W   = 14,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned DLL_WAIT = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        casLat,
  input  logic [2:0]        wrRec,
  input  logic [CNT_W-1:0]  tRp,
  input  logic [CNT_W-1:0]  tMrd,
  input  logic [CNT_W-1:0]  tRfc,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone
);

  seqStrobeT strobe;
  logic      waitZero;
  logic      lastStep;

  dramInitCtrl ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .waitZero (waitZero),
    .lastStep (lastStep),
    .strobe   (strobe)
  );

  dramInitPath #(
    .BA_W     (BA_W),
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .DLL_WAIT (DLL_WAIT)
  ) path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .casLat   (casLat),
    .wrRec    (wrRec),
    .tRp      (tRp),
    .tMrd     (tMrd),
    .tRfc     (tRfc),
    .waitZero (waitZero),
    .lastStep (lastStep),
    .cke      (cke),
    .csN      (csN),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .ba       (ba),
    .addr     (addr),
    .initDone (initDone)
  );

endmodule

// File: rtl/dramInitSeqChk.sv
module dramInitSeqChk #(
  parameter int unsigned BA_W   = 3,
  parameter int unsigned ADDR_W = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              cke,
  input logic              csN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              initDone,
  input logic [2:0]        casLat,
  input logic [2:0]        wrRec
);

  logic isNop, isPre, isMrs;
  assign isNop = !csN &&  rasN &&  casN &&  weN;
  assign isPre = !csN && !rasN &&  casN && !weN;
  assign isMrs = !csN && !rasN && !casN && !weN;

  always @(negedge clk) begin
    if (!rstN) begin
      // R1
      reset_idle_chk: assert (!cke && isNop && ba == '0 && addr == '0 && !initDone)
        else $error("reset state wrong");
    end
  end

  // R2
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cke |=> cke);

  // R2
  no_cmd_low_cke_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> isNop);

  // R8
  pre_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    isPre |-> (addr[10] && ba == '0));

  // R6
  main_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isMrs && ba == '0) |-> (addr[2:0] == 3'b011 && addr[6:4] == casLat &&
                             addr[11:9] == wrRec - 3'd1));

  // R7
  ext_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isMrs && ba == BA_W'(1)) |-> addr[2]);

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> (isNop && cke));

endmodule

bind dramInitSeq dramInitSeqChk #(.BA_W(BA_W), .ADDR_W(ADDR_W)) chk (
  .clk      (clk),
  .rstN     (rstN),
  .cke      (cke),
  .csN      (csN),
  .rasN     (rasN),
  .casN     (casN),
  .weN      (weN),
  .ba       (ba),
  .addr     (addr),
  .initDone (initDone),
  .casLat   (casLat),
  .wrRec    (wrRec)
);

// File: tb/dramInitSeq_test.sv
`timescale 1ns/1ps
module dramInitSeq_test;

  localparam int BA_W     = 3;
  localparam int ADDR_W   = 14;
  localparam int CNT_W    = 8;
  localparam int DLL_WAIT = 200;

  logic              clk = 1'b0;
  logic              rstN;
  logic              start;
  logic [2:0]        casLat, wrRec;
  logic [CNT_W-1:0]  tRp, tMrd, tRfc;
  logic              cke, csN, rasN, casN, weN, initDone;
  logic [BA_W-1:0]   ba;
  logic [ADDR_W-1:0] addr;

  dramInitSeq #(.BA_W(BA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DLL_WAIT(DLL_WAIT)) uut (
    .clk(clk), .rstN(rstN), .start(start), .casLat(casLat), .wrRec(wrRec),
    .tRp(tRp), .tMrd(tMrd), .tRfc(tRfc), .cke(cke), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .ba(ba), .addr(addr), .initDone(initDone)
  );

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic              cke;
    logic [3:0]        pins;   // {csN,rasN,casN,weN}
    logic [BA_W-1:0]   ba;
    logic [ADDR_W-1:0] addr;
    logic              done;
  } busWordT;

  localparam logic [3:0] P_NOP = 4'b0111;
  localparam logic [3:0] P_PRE = 4'b0010;
  localparam logic [3:0] P_REF = 4'b0001;
  localparam logic [3:0] P_MRS = 4'b0000;

  busWordT expQ[$];
  string   tagQ[$];
  busWordT expCur;
  string   expTag;
  int      phase;
  int      checks = 0;
  int      fails  = 0;
  int      preCnt, refCnt, mrsCnt;
  bit      finished = 0;

  function automatic busWordT mk(logic k, logic [3:0] p, int b, int a, logic d);
    busWordT w;
    w.cke = k; w.pins = p; w.ba = BA_W'(b); w.addr = ADDR_W'(a); w.done = d;
    return w;
  endfunction

  function automatic busWordT idleWord();
    return mk(1'b0, P_NOP, 0, 0, 1'b0);
  endfunction

  function automatic busWordT doneWord();
    return mk(1'b1, P_NOP, 0, 0, 1'b1);
  endfunction

  function automatic int mainVal(int dll);
    return 3 + (int'(casLat) * 16) + (dll * 256) + ((int'(wrRec) - 1) * 512);
  endfunction

  function automatic int extVal(int ocd);
    return 4 + (ocd ? (7 * 128) : 0);
  endfunction

  task automatic pushCmd(logic [3:0] p, int b, int a, int w, string t);
    expQ.push_back(mk(1'b1, p, b, a, 1'b0)); tagQ.push_back(t);
    for (int i = 0; i < w; i++) begin
      expQ.push_back(mk(1'b1, P_NOP, 0, 0, 1'b0)); tagQ.push_back("R5");
    end
  endtask

  task automatic buildRun();
    int wM, wF, wP;
    wP = int'(tRp);
    wM = (tMrd == 0) ? 0 : int'(tMrd) - 1;
    wF = (tRfc == 0) ? 0 : int'(tRfc) - 1;
    expQ.push_back(mk(1'b1, P_NOP, 0, 0, 1'b0)); tagQ.push_back("R2");
    pushCmd(P_PRE, 0, 1024, wP, "R8");
    pushCmd(P_MRS, 2, 0, wM, "R3");
    pushCmd(P_MRS, 3, 0, wM, "R3");
    pushCmd(P_MRS, 1, extVal(0), wM, "R7");
    pushCmd(P_MRS, 0, mainVal(1), wM, "R6");
    pushCmd(P_PRE, 0, 1024, wP, "R8");
    pushCmd(P_REF, 0, 0, wF, "R4");
    pushCmd(P_REF, 0, 0, wF, "R4");
    pushCmd(P_MRS, 0, mainVal(0), wM, "R6");
    pushCmd(P_MRS, 1, extVal(1), wM, "R7");
    pushCmd(P_MRS, 1, extVal(0), wM, "R7");
    for (int i = 0; i < DLL_WAIT; i++) begin
      expQ.push_back(mk(1'b1, P_NOP, 0, 0, 1'b0)); tagQ.push_back("R9");
    end
  endtask

  // reference model: expected bus after each edge
  always @(posedge clk) begin
    if (!rstN) begin
      expQ.delete(); tagQ.delete();
      phase = 0; expCur = idleWord(); expTag = "R2";
    end else begin
      case (phase)
        0: if (start) begin
             buildRun();
             phase = 1;
             expCur = expQ.pop_front(); expTag = tagQ.pop_front();
           end
        1: if (expQ.size() > 0) begin
             expCur = expQ.pop_front(); expTag = tagQ.pop_front();
           end else begin
             expCur = doneWord(); expTag = "R9"; phase = 2;
           end
        default: begin expCur = doneWord(); expTag = "R9"; end
      endcase
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    busWordT act, e;
    string   t;
    if (!finished) begin
      act.cke = cke; act.pins = {csN, rasN, casN, weN};
      act.ba = ba; act.addr = addr; act.done = initDone;
      if (!rstN) begin e = idleWord(); t = "R1"; end
      else begin e = expCur; t = expTag; end
      checks++;
      if (act !== e) begin
        fails++;
        $display("FAIL %s at %0t: actual cke=%b pins=%b ba=%0d addr=%h done=%b expected cke=%b pins=%b ba=%0d addr=%h done=%b",
                 t, $time, act.cke, act.pins, act.ba, act.addr, act.done,
                 e.cke, e.pins, e.ba, e.addr, e.done);
      end
      if (rstN) begin
        if ({csN, rasN, casN, weN} == P_PRE) preCnt++;
        if ({csN, rasN, casN, weN} == P_REF) refCnt++;
        if ({csN, rasN, casN, weN} == P_MRS) mrsCnt++;
      end
    end
  end

  task automatic check(bit ok, string tag, string what, int actV, int expV);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual %0d expected %0d", tag, what, actV, expV);
    end
  endtask

  task automatic doReset();
    @(posedge clk); #1 rstN = 1'b0; start = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic pulseStart();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic setCfg(int cl, int wr, int rp, int mrd, int rfc);
    casLat = 3'(cl); wrRec = 3'(wr);
    tRp = CNT_W'(rp); tMrd = CNT_W'(mrd); tRfc = CNT_W'(rfc);
  endtask

  task automatic clearCounts();
    preCnt = 0; refCnt = 0; mrsCnt = 0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (initDone !== 1'b1 && n < 5000) begin @(posedge clk); n++; end
    check(initDone === 1'b1, "R9", "initDone after sequence", int'(initDone), 1);
  endtask

  task automatic checkCounts(string tag);
    check(preCnt == 2, tag, "precharge count", preCnt, 2);
    check(refCnt == 2, tag, "refresh count", refCnt, 2);
    check(mrsCnt == 7, tag, "mode load count", mrsCnt, 7);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0;
    setCfg(4, 3, 3, 2, 5);
    clearCounts();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (6) @(posedge clk);   // R1 / R2: idle before start

    // run A: mid-range gaps, extra start mid-run and after done (R10)
    clearCounts();
    pulseStart();
    repeat (20) @(posedge clk);
    pulseStart();                // R10: ignored while busy
    waitDone();
    repeat (3) @(posedge clk);
    checkCounts("R3");
    pulseStart();                // R10: ignored after done
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(initDone === 1'b1 && rasN && casN && weN, "R10", "done word kept after start", int'(initDone), 1);
    check(mrsCnt == 7, "R10", "no restart after done", mrsCnt, 7);

    // run B: minimum gaps, tMrd of zero saturates (R5)
    doReset();
    clearCounts();
    setCfg(6, 6, 1, 0, 1);
    repeat (2) @(posedge clk);
    pulseStart();
    waitDone();
    repeat (3) @(posedge clk);
    checkCounts("R5");

    // run C: reset mid-run, then complete (R1)
    doReset();
    setCfg(3, 2, 2, 1, 9);
    pulseStart();
    repeat (15) @(posedge clk);
    #1 rstN = 1'b0;
    @(negedge clk);
    check(cke === 1'b0 && initDone === 1'b0, "R1", "cke/initDone in reset", int'(cke), 0);
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    clearCounts();
    repeat (3) @(posedge clk);
    pulseStart();
    waitDone();
    repeat (3) @(posedge clk);
    checkCounts("R3");

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL R9: watchdog expired actual running expected finished");
      summary();
      $finish;
    end
  end

endmodule